// File: doc/BRIEF.md
# Bank Register Write Decoder for a Switchable Cartridge Controller

This block sits on the CPU write path of a bank-switching cartridge controller. Each accepted write carries a 16-bit address and an 8-bit value. The block classifies the write by the address bits that the mask 0xE001 keeps. It then updates one of three things: a bank-select register, one of eight bank data registers, or the nametable mirroring bit. From that stored state it produces, without further delay, four 8 KB program bank numbers, eight 1 KB character bank numbers and a mirroring flag. A later outer-bank merge stage consumes these numbers.

The write port is a valid/ready stream that never applies back-pressure. `wr_ready` is held high, so every cycle with `wr_valid` high transfers one write. A transferred write changes the outputs from the following clock edge on. Two bits of the select register set the layout. One moves the switchable program slot between the first and third windows. The other exchanges the two 4 KB halves of the character space. Writes meant for the interrupt counter are decoded here only so they can be recognised, and they are dropped.

Top module: `bank_wr_decoder`

## Requirements
- R1: After reset, program slots 0 to 3 read 0, 1, PRG_COUNT-2 and PRG_COUNT-1. Character banks 0 to 7 read 0 to 7. The mirroring flag reads 0, meaning vertical.
- R2: `wr_ready` is always 1. A write with `wr_valid` high is classified by (wr_addr AND 0xE001): 0x8000 is select, 0x8001 is data and 0xA000 is mirroring. Any address that aliases to one of these, such as 0x9FFE or 0xBFFE, behaves the same. The effect shows on the outputs in the cycle after the transfer.
- R3: Bits 2:0 of the select value name the data register (0 to 7) that later data writes update. The selection stays in force until the next select write.
- R4: Data registers 0 and 1 each feed two character banks, with bit 0 of the data forced low for the first bank and high for the second. Register 0 feeds banks 0 and 1, and register 1 feeds banks 2 and 3 (when select bit 7 is 0).
- R5: Data registers 2, 3, 4 and 5 each feed one character bank: banks 4, 5, 6 and 7 respectively (when select bit 7 is 0).
- R6: The low PRG_W bits of data register 6 drive program slot 0 when select bit 6 is 0, and slot 2 when it is 1. The other of those two slots then reads PRG_COUNT-2.
- R7: The low PRG_W bits of data register 7 always drive program slot 1. Slot 3 always reads PRG_COUNT-1.
- R8: When select bit 7 is 1, character banks 0–3 and 4–4+3 swap sources: output bank i shows what bank i XOR 4 would show with the bit clear. Stored register values are kept, so clearing the bit restores the plain layout.
- R9: A mirroring write copies bit 0 of the data to the mirroring flag (1 is horizontal, 0 is vertical) and ignores the other bits.
- R10: Writes whose masked address is 0xA001, 0xC000, 0xC001, 0xE000 or 0xE001, writes below 0x8000, and cycles with `wr_valid` low change no output and leave the select register untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Write transfer request |
| wr_ready | output | 1 | Always 1; the block never stalls |
| wr_addr | input | 16 | CPU write address |
| wr_data | input | 8 | CPU write value |
| prg_bank_o | output | 4*PRG_W | Program bank per 8 KB slot, slot 0 in the low bits |
| chr_bank_o | output | 8*CHR_W | Character bank per 1 KB slot, slot 0 in the low bits |
| mirror_horiz_o | output | 1 | 1 for horizontal, 0 for vertical mirroring |

## Verification
The hardest states to reach from the ports are the ones where both layout bits flip while the data registers hold distinct, non-reset values. A swap that read the wrong register, or that destroyed stored values, would otherwise look correct. The stimulus first loads every data register with a recognisable pattern under the plain layout. It then toggles each mode bit in turn, including a data write made while the character halves are swapped. Finally it returns both bits to zero, to confirm that the original mapping comes back.

// File: rtl/bank_wr_pkg.sv
package bank_wr_pkg;
  localparam logic [15:0] ADDR_MASK = 16'hE001;
  localparam logic [15:0] ADDR_SEL  = 16'h8000;
  localparam logic [15:0] ADDR_DATA = 16'h8001;
  localparam logic [15:0] ADDR_MIRR = 16'hA000;

  typedef enum logic [1:0] {
    CMD_NONE = 2'd0,
    CMD_SEL  = 2'd1,
    CMD_DATA = 2'd2,
    CMD_MIRR = 2'd3
  } wr_cmd_e;
endpackage

// File: rtl/bank_wr_classify.sv
module bank_wr_classify
  import bank_wr_pkg::*;
(
  input  logic        valid_i,
  input  logic [15:0] addr_i,
  output wr_cmd_e     cmd_o
);
  logic [15:0] masked;
  assign masked = addr_i & ADDR_MASK;

  always_comb begin
    cmd_o = CMD_NONE;
    if (valid_i) begin
      if (masked == ADDR_SEL)       cmd_o = CMD_SEL;
      else if (masked == ADDR_DATA) cmd_o = CMD_DATA;
      else if (masked == ADDR_MIRR) cmd_o = CMD_MIRR;
    end
  end
endmodule

// File: rtl/bank_wr_regs.sv
module bank_wr_regs
  import bank_wr_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int NUM_REGS = 8
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  wr_cmd_e                          cmd_i,
  input  logic [DATA_W-1:0]                data_i,
  output logic [$clog2(NUM_REGS)-1:0]      idx_o,
  output logic                             prg_swap_o,
  output logic                             chr_swap_o,
  output logic [NUM_REGS-1:0][DATA_W-1:0]  regs_o,
  output logic                             mirror_o
);
  localparam int IDX_W = $clog2(NUM_REGS);

  function automatic logic [DATA_W-1:0] reset_value(int n);
    if (n == 0)      return '0;
    else if (n == 1) return DATA_W'(2);
    else if (n < 6)  return DATA_W'(n + 2);
    else if (n == 6) return '0;
    else             return DATA_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_o      <= '0;
      prg_swap_o <= 1'b0;
      chr_swap_o <= 1'b0;
      mirror_o   <= 1'b0;
    end else begin
      if (cmd_i == CMD_SEL) begin
        idx_o      <= data_i[IDX_W-1:0];
        prg_swap_o <= data_i[6];
        chr_swap_o <= data_i[7];
      end
      if (cmd_i == CMD_MIRR) mirror_o <= data_i[0];
    end
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n)
        regs_o[g] <= reset_value(g);
      else if (cmd_i == CMD_DATA && idx_o == IDX_W'(g))
        regs_o[g] <= data_i;
    end

    AST_DATA_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_i == CMD_DATA && idx_o == IDX_W'(g)) |=> regs_o[g] == $past(data_i)); // R3
  end

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_i == CMD_NONE) |=> ($stable(regs_o) && $stable(idx_o) && $stable(prg_swap_o)
                            && $stable(chr_swap_o) && $stable(mirror_o))); // R10

  AST_MIRROR_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_i == CMD_MIRR) |=> mirror_o == $past(data_i[0])); // R9
endmodule

// File: rtl/bank_wr_prg_map.sv
module bank_wr_prg_map #(
  parameter int PRG_W = 6,
  parameter int PRG_COUNT = 64
) (
  input  logic               swap_i,
  input  logic [PRG_W-1:0]   sw_a_i,
  input  logic [PRG_W-1:0]   sw_b_i,
  output logic [4*PRG_W-1:0] bank_o
);
  localparam logic [PRG_W-1:0] NEXT_LAST = PRG_W'(PRG_COUNT - 2);
  localparam logic [PRG_W-1:0] LAST      = PRG_W'(PRG_COUNT - 1);

  always_comb begin
    bank_o[0*PRG_W +: PRG_W] = swap_i ? NEXT_LAST : sw_a_i;
    bank_o[1*PRG_W +: PRG_W] = sw_b_i;
    bank_o[2*PRG_W +: PRG_W] = swap_i ? sw_a_i : NEXT_LAST;
    bank_o[3*PRG_W +: PRG_W] = LAST;
  end
endmodule

// File: rtl/bank_wr_chr_map.sv
module bank_wr_chr_map #(
  parameter int DATA_W = 8,
  parameter int CHR_W = 8
) (
  input  logic                     swap_i,
  input  logic [5:0][DATA_W-1:0]   regs_i,
  output logic [8*CHR_W-1:0]       bank_o
);
  logic [7:0][CHR_W-1:0] plain;

  for (genvar p = 0; p < 2; p++) begin : g_pair
    assign plain[2*p]     = {CHR_W'(regs_i[p]) >> 1, 1'b0};
    assign plain[2*p + 1] = {CHR_W'(regs_i[p]) >> 1, 1'b1};
  end
  for (genvar s = 2; s < 6; s++) begin : g_single
    assign plain[s + 2] = CHR_W'(regs_i[s]);
  end
  for (genvar o = 0; o < 8; o++) begin : g_out
    assign bank_o[o*CHR_W +: CHR_W] = swap_i ? plain[o ^ 4] : plain[o];
  end
endmodule

// File: rtl/bank_wr_decoder.sv
module bank_wr_decoder
  import bank_wr_pkg::*;
#(
  parameter int PRG_W = 6,
  parameter int CHR_W = 8,
  parameter int PRG_COUNT = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_valid,
  output logic               wr_ready,
  input  logic [15:0]        wr_addr,
  input  logic [7:0]         wr_data,
  output logic [4*PRG_W-1:0] prg_bank_o,
  output logic [8*CHR_W-1:0] chr_bank_o,
  output logic               mirror_horiz_o
);
  localparam int DATA_W = 8;
  localparam int NUM_REGS = 8;
  localparam int IDX_W = $clog2(NUM_REGS);

  wr_cmd_e                          cmd;
  logic [IDX_W-1:0]                 idx;
  logic                             prg_swap;
  logic                             chr_swap;
  logic [NUM_REGS-1:0][DATA_W-1:0]  regs;

  assign wr_ready = 1'b1;

  bank_wr_classify u_classify (
    .valid_i (wr_valid),
    .addr_i  (wr_addr),
    .cmd_o   (cmd)
  );

  bank_wr_regs #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_i      (cmd),
    .data_i     (wr_data),
    .idx_o      (idx),
    .prg_swap_o (prg_swap),
    .chr_swap_o (chr_swap),
    .regs_o     (regs),
    .mirror_o   (mirror_horiz_o)
  );

  bank_wr_prg_map #(.PRG_W(PRG_W), .PRG_COUNT(PRG_COUNT)) u_prg (
    .swap_i (prg_swap),
    .sw_a_i (regs[6][PRG_W-1:0]),
    .sw_b_i (regs[7][PRG_W-1:0]),
    .bank_o (prg_bank_o)
  );

  bank_wr_chr_map #(.DATA_W(DATA_W), .CHR_W(CHR_W)) u_chr (
    .swap_i (chr_swap),
    .regs_i (regs[5:0]),
    .bank_o (chr_bank_o)
  );

  AST_PRG_SWITCHABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_DATA && idx == IDX_W'(6)) |=>
      (prg_swap ? prg_bank_o[2*PRG_W +: PRG_W] : prg_bank_o[0 +: PRG_W])
        == $past(wr_data[PRG_W-1:0])); // R6

  AST_PRG_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_DATA && idx == IDX_W'(7)) |=>
      prg_bank_o[PRG_W +: PRG_W] == $past(wr_data[PRG_W-1:0])); // R7

  AST_CHR_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_DATA && idx == '0 && !chr_swap) |=>
      (chr_bank_o[0 +: CHR_W] == (CHR_W'($past(wr_data)) & ~CHR_W'(1)) &&
       chr_bank_o[CHR_W +: CHR_W] == (CHR_W'($past(wr_data)) | CHR_W'(1)))); // R4

  AST_READY_HIGH: assert property (@(posedge clk) disable iff (!rst_n) wr_ready); // R2
endmodule

// File: tb/bank_wr_decoder_tb.sv
module bank_wr_decoder_tb;
  localparam int PRG_W = 6;
  localparam int CHR_W = 8;
  localparam int PRG_COUNT = 64;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               wr_valid = 1'b0;
  logic               wr_ready;
  logic [15:0]        wr_addr = '0;
  logic [7:0]         wr_data = '0;
  logic [4*PRG_W-1:0] prg_bank_o;
  logic [8*CHR_W-1:0] chr_bank_o;
  logic               mirror_horiz_o;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  bank_wr_decoder #(.PRG_W(PRG_W), .CHR_W(CHR_W), .PRG_COUNT(PRG_COUNT)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .prg_bank_o(prg_bank_o),
    .chr_bank_o(chr_bank_o), .mirror_horiz_o(mirror_horiz_o)
  );

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  function automatic int prg(input int s);
    return int'(prg_bank_o[s*PRG_W +: PRG_W]);
  endfunction
  function automatic int chr(input int s);
    return int'(chr_bank_o[s*CHR_W +: CHR_W]);
  endfunction

  task automatic t_reset;
    chk("R1", "prg0", prg(0), 0);
    chk("R1", "prg1", prg(1), 1);
    chk("R1", "prg2", prg(2), PRG_COUNT - 2);
    chk("R1", "prg3", prg(3), PRG_COUNT - 1);
    for (int i = 0; i < 8; i++) chk("R1", "chr", chr(i), i);
    chk("R1", "mirror", int'(mirror_horiz_o), 0);
    chk("R2", "ready", int'(wr_ready), 1);
  endtask

  task automatic t_chr_pairs;
    wr(16'h8000, 8'h00); wr(16'h8001, 8'h25);
    chk("R4", "chr0", chr(0), 8'h24);
    chk("R4", "chr1", chr(1), 8'h25);
    wr(16'h8000, 8'h01); wr(16'h8001, 8'h80);
    chk("R4", "chr2", chr(2), 8'h80);
    chk("R4", "chr3", chr(3), 8'h81);
    chk("R3", "chr0 untouched", chr(0), 8'h24);
  endtask

  task automatic t_chr_singles;
    for (int i = 2; i < 6; i++) begin
      wr(16'h8000, 8'(i)); wr(16'h8001, 8'(8'h10 + i));
    end
    for (int i = 4; i < 8; i++) chk("R5", "chr single", chr(i), 8'h10 + i - 2);
  endtask

  task automatic t_prg_normal;
    wr(16'h8000, 8'h06); wr(16'h8001, 8'hC5);
    chk("R6", "slot0", prg(0), 8'h05);
    chk("R6", "slot2 fixed", prg(2), PRG_COUNT - 2);
    wr(16'h8000, 8'h07); wr(16'h8001, 8'h4A);
    chk("R7", "slot1", prg(1), 8'h0A);
    chk("R7", "slot3", prg(3), PRG_COUNT - 1);
  endtask

  task automatic t_prg_swap;
    wr(16'h8000, 8'h46);
    chk("R6", "swap slot0", prg(0), PRG_COUNT - 2);
    chk("R6", "swap slot2", prg(2), 8'h05);
    wr(16'h8001, 8'h11);
    chk("R6", "swap write slot2", prg(2), 8'h11);
    chk("R6", "swap write slot0", prg(0), PRG_COUNT - 2);
    chk("R7", "swap slot1", prg(1), 8'h0A);
    wr(16'h8000, 8'h06);
    chk("R6", "unswap slot0", prg(0), 8'h11);
    chk("R6", "unswap slot2", prg(2), PRG_COUNT - 2);
  endtask

  task automatic t_chr_swap;
    wr(16'h8000, 8'h80);
    chk("R8", "chr0", chr(0), 8'h12);
    chk("R8", "chr3", chr(3), 8'h15);
    chk("R8", "chr4", chr(4), 8'h24);
    chk("R8", "chr7", chr(7), 8'h81);
    wr(16'h8000, 8'h82); wr(16'h8001, 8'h33);
    chk("R8", "swapped write chr0", chr(0), 8'h33);
    wr(16'h8000, 8'h02);
    chk("R8", "restore chr4", chr(4), 8'h33);
    chk("R8", "restore chr0", chr(0), 8'h24);
  endtask

  task automatic t_mirror;
    wr(16'hA000, 8'h01); chk("R9", "mirror set", int'(mirror_horiz_o), 1);
    wr(16'hA000, 8'hFE); chk("R9", "mirror clear", int'(mirror_horiz_o), 0);
    wr(16'hA000, 8'h03); chk("R9", "mirror set2", int'(mirror_horiz_o), 1);
  endtask

  task automatic t_ignored;
    logic [4*PRG_W-1:0] p0;
    logic [8*CHR_W-1:0] c0;
    wr(16'h8000, 8'h00);
    p0 = prg_bank_o; c0 = chr_bank_o;
    wr(16'hA001, 8'h00);
    wr(16'hC000, 8'hFF); wr(16'hC001, 8'hC7);
    wr(16'hE000, 8'h87); wr(16'hE001, 8'hFF);
    wr(16'h6000, 8'h47); wr(16'h0001, 8'hFF);
    @(negedge clk);
    wr_addr = 16'h8001; wr_data = 8'h77;
    @(negedge clk);
    wr_addr = 16'h8000;
    @(negedge clk);
    chk("R10", "prg held", int'(prg_bank_o != p0), 0);
    chk("R10", "chr held", int'(chr_bank_o != c0), 0);
    chk("R10", "mirror held", int'(mirror_horiz_o), 1);
    wr(16'h8001, 8'h3F);
    chk("R10", "select held chr0", chr(0), 8'h3E);
    chk("R10", "select held chr4", chr(4), 8'h33);
  endtask

  task automatic t_alias;
    wr(16'h9FFE, 8'h07); wr(16'h9FFF, 8'h2B);
    chk("R2", "alias slot1", prg(1), 8'h2B);
    wr(16'hBFFE, 8'h00);
    chk("R2", "alias mirror", int'(mirror_horiz_o), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_chr_pairs();
    t_chr_singles();
    t_prg_normal();
    t_prg_swap();
    t_chr_swap();
    t_mirror();
    t_ignored();
    t_alias();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule